// File: doc/BRIEF.md
# Dual-Processor Interrupt Controller

This block holds the interrupt state of two processors side by side. Each processor owns three 32-bit registers: a global switch (only bit 0 matters for gating), a per-source mask, and a set of pending flags. Software reaches them through a single register port. The port carries a processor select, a write strobe, an address, write data, and combinational read data.

Peripherals raise requests on a flat vector that holds one bit per (processor, source) pair. A request is admitted only when that processor's global switch bit 0 is 1 and its mask bit for the source is 1. An admitted request sets the matching pending flag. A refused request leaves no trace at all. Software acknowledges by writing ones to the pending register. Each processor has one level interrupt line. The line is high while any pending flag is unmasked and the global switch is on.

The block has no state machine. All of its state lives in the three registers per processor.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, every register of both processors reads 0 and both interrupt lines are low.
- R2: A write at offset 0x208 replaces the addressed processor's global-switch register with all 32 written bits. A read at 0x208 returns the stored value.
- R3: A write at offset 0x210 replaces the addressed processor's source-mask register. A read at 0x210 returns the stored value.
- R4: A request on source n of processor c is admitted when bit 0 of c's global switch is 1 and bit n of c's mask is 1. An admitted request sets pending bit n (value 1<<n) at the next clock edge. The pending register is read at offset 0x214. Request bit c*32+n of the request vector carries source n of processor c.
- R5: While bit 0 of the global switch is 0, requests are discarded and never latched. This holds even when the other bits are 1, and switching bit 0 on later does not bring them back.
- R6: A request for a source whose mask bit is 0 is discarded and never latched. Gating uses the register values held before any write in the same cycle.
- R7: A write at 0x214 clears each pending bit that is 1 in the written data and keeps every other bit.
- R8: When an admitted request and a clearing write hit the same pending bit in one cycle, the bit ends up set.
- R9: Several requests admitted in the same cycle are all latched.
- R10: A processor's interrupt line is high exactly when global-switch bit 0 is 1 and (pending AND mask) is non-zero. The line drops once the flags are cleared, the mask is removed, or the switch is turned off.
- R11: The two processors' registers are independent. Accesses and requests for one processor leave the other's registers unchanged.
- R12: A write to any other offset changes no register, and a read from any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cpu | input | 1 | Processor whose registers are accessed |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_cpu and bus_addr |
| src_req | input | 64 | Request pulses, bit c*32+n is source n of processor c |
| cpu_irq | output | 2 | Interrupt line per processor |

## Verification
The hardest case to reach is a request and an acknowledge landing on the same pending bit in the same cycle. Close behind it is proving that a refused request left nothing behind once the gate later opens. The bench drives a request pulse and a clearing write on the same negative edge, then reads the pending register. For discarded requests, it floods every source while the switch has bit 0 clear but all other bits set. It then turns the switch on and reads the flags back. Acceptance and refusal are swept over every source of both processors against a mask pattern, with the expected flag computed by shifting.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
package icu_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_MASTER = 12'h208;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h210;
    localparam logic [ADDR_W-1:0] OFS_FLAGS  = 12'h214;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_MASTER,
        REG_MASK,
        REG_FLAGS
    } icu_reg_e;
endpackage

// File: rtl/icu_decode.sv
`timescale 1ns/1ps
module icu_decode
    import icu_pkg::*;
#(
    parameter int NUM_CPU = 2,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_W-1:0]  cpu,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output icu_reg_e          kind,
    output logic [NUM_CPU-1:0] we_master,
    output logic [NUM_CPU-1:0] we_mask,
    output logic [NUM_CPU-1:0] we_flags
);
    always_comb begin
        unique case (addr)
            OFS_MASTER: kind = REG_MASTER;
            OFS_MASK:   kind = REG_MASK;
            OFS_FLAGS:  kind = REG_FLAGS;
            default:    kind = REG_NONE;
        endcase
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
        logic hit;
        assign hit          = wr && (cpu == CPU_W'(c));
        assign we_master[c] = hit && (kind == REG_MASTER);
        assign we_mask[c]   = hit && (kind == REG_MASK);
        assign we_flags[c]  = hit && (kind == REG_FLAGS);
    end

    // R11
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_master, we_mask, we_flags}));
    // R12
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || kind == REG_NONE) |-> ({we_master, we_mask, we_flags} == '0));
endmodule

// File: rtl/icu_cpu_bank.sv
`timescale 1ns/1ps
module icu_cpu_bank
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_master,
    input  logic              we_mask,
    input  logic              we_flags,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] req,
    output logic [DATA_W-1:0] master_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] flags_q,
    output logic              irq
);
    logic [DATA_W-1:0] admit;
    logic [DATA_W-1:0] ack;
    logic [DATA_W-1:0] flags_d;

    assign admit   = req & mask_q & {DATA_W{master_q[0]}};
    assign ack     = we_flags ? wdata : '0;
    assign flags_d = (flags_q & ~ack) | admit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= '0;
            mask_q   <= '0;
            flags_q  <= '0;
        end else begin
            if (we_master) master_q <= wdata;
            if (we_mask)   mask_q   <= wdata;
            flags_q <= flags_d;
        end
    end

    assign irq = master_q[0] && ((flags_q & mask_q) != '0);

    // R5 R6
    no_gated_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((flags_q & ~$past(flags_q)) &
               ~($past(req) & $past(mask_q) & {DATA_W{$past(master_q[0])}})) == '0);
    // R4 R8 R9
    admit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> (($past(req) & $past(mask_q) & {DATA_W{$past(master_q[0])}}) & ~flags_q) == '0);
    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_flags |=> (flags_q & $past(wdata) & ~$past(req)) == '0);
    // R10
    irq_needs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> master_q[0]);
endmodule

// File: rtl/dual_irq_ctrl.sv
`timescale 1ns/1ps
module dual_irq_ctrl
    import icu_pkg::*;
#(
    parameter int NUM_CPU = 2,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CPU_W-1:0]          bus_cpu,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_CPU*DATA_W-1:0] src_req,
    output logic [NUM_CPU-1:0]        cpu_irq
);
    icu_reg_e           kind;
    logic [NUM_CPU-1:0] we_master, we_mask, we_flags;
    logic [DATA_W-1:0]  master_a [NUM_CPU];
    logic [DATA_W-1:0]  mask_a   [NUM_CPU];
    logic [DATA_W-1:0]  flags_a  [NUM_CPU];

    icu_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu       (bus_cpu),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .kind      (kind),
        .we_master (we_master),
        .we_mask   (we_mask),
        .we_flags  (we_flags)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        icu_cpu_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_master (we_master[c]),
            .we_mask   (we_mask[c]),
            .we_flags  (we_flags[c]),
            .wdata     (bus_wdata),
            .req       (src_req[c*DATA_W +: DATA_W]),
            .master_q  (master_a[c]),
            .mask_q    (mask_a[c]),
            .flags_q   (flags_a[c]),
            .irq       (cpu_irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (bus_cpu == CPU_W'(c)) begin
                unique case (kind)
                    REG_MASTER: bus_rdata = master_a[c];
                    REG_MASK:   bus_rdata = mask_a[c];
                    REG_FLAGS:  bus_rdata = flags_a[c];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REG_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_dual_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dual_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  bus_cpu = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_req = '0;
    logic [1:0]  cpu_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_SW = 12'h208, A_MK = 12'h210, A_PF = 12'h214;

    always #10 clk = ~clk;

    dual_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_req(src_req), .cpu_irq(cpu_irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int c, logic [11:0] a, logic [31:0] d);
        bus_cpu = c[0:0]; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int c, logic [11:0] a, output logic [31:0] d);
        bus_cpu = c[0:0]; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(logic [63:0] r);
        src_req = r;
        @(negedge clk);
        src_req = '0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < 2; c++) begin
            rd(c, A_SW, v); chk("R1 switch", v, 0);
            rd(c, A_MK, v); chk("R1 mask", v, 0);
            rd(c, A_PF, v); chk("R1 flags", v, 0);
        end
        chk("R1 irq", {30'd0, cpu_irq}, 0);

        // R2 R3 R11 write/readback, independence
        wr(0, A_SW, 32'hDEAD_BEEF);
        wr(0, A_MK, 32'h1234_5678);
        wr(1, A_SW, 32'h0F0F_0F0E);
        wr(1, A_MK, 32'hCAFE_F00D);
        rd(0, A_SW, v); chk("R2 cpu0 switch", v, 32'hDEAD_BEEF);
        rd(0, A_MK, v); chk("R3 cpu0 mask", v, 32'h1234_5678);
        rd(1, A_SW, v); chk("R2 R11 cpu1 switch", v, 32'h0F0F_0F0E);
        rd(1, A_MK, v); chk("R3 R11 cpu1 mask", v, 32'hCAFE_F00D);

        // R12 unmapped offset
        wr(0, 12'h20C, 32'hFFFF_FFFF);
        wr(1, 12'h000, 32'hFFFF_FFFF);
        rd(0, 12'h20C, v); chk("R12 unmapped read", v, 0);
        rd(0, A_SW, v); chk("R12 switch untouched", v, 32'hDEAD_BEEF);
        rd(1, A_MK, v); chk("R12 mask untouched", v, 32'hCAFE_F00D);

        // R4 R6 R10 sweep every source, both cpus
        for (int c = 0; c < 2; c++) begin
            pat = (c == 0) ? 32'h9669_0FF0 : 32'h3C3C_A5A5;
            wr(c, A_SW, 32'h1);
            wr(c, A_MK, pat);
            for (int n = 0; n < 32; n++) begin
                pulse(64'd1 << (c * 32 + n));
                e = pat & (32'd1 << n);
                rd(c, A_PF, v); chk("R4 R6 latched flag", v, e);
                chk("R10 irq level", {31'd0, cpu_irq[c]}, {31'd0, e != 0});
                rd(1 - c, A_PF, v); chk("R11 other cpu flags", v, 0);
                wr(c, A_PF, 32'hFFFF_FFFF);
                rd(c, A_PF, v); chk("R7 flags cleared", v, 0);
                chk("R10 irq falls", {31'd0, cpu_irq[c]}, 0);
            end
        end

        // R5 switch bit 0 off, other bits on
        wr(0, A_MK, 32'hFFFF_FFFF);
        wr(0, A_SW, 32'hFFFF_FFFE);
        pulse(64'h0000_0000_FFFF_FFFF);
        rd(0, A_PF, v); chk("R5 dropped while off", v, 0);
        chk("R5 irq low", {31'd0, cpu_irq[0]}, 0);
        wr(0, A_SW, 32'h1);
        rd(0, A_PF, v); chk("R5 not revived", v, 0);

        // R9 simultaneous requests
        pulse(64'h0000_0000_F0F0_1234);
        rd(0, A_PF, v); chk("R9 all latched", v, 32'hF0F0_1234);

        // R7 partial clear
        wr(0, A_PF, 32'h00F0_0034);
        rd(0, A_PF, v); chk("R7 partial clear", v, 32'hF000_1200);

        // R8 request and clear collide on bit 9; bit 12 just cleared
        src_req = 64'h0000_0000_0000_0200;
        wr(0, A_PF, 32'h0000_1200);
        src_req = '0;
        rd(0, A_PF, v); chk("R8 request wins", v, 32'hF000_0200);

        // R10 line follows mask and switch
        chk("R10 irq high", {31'd0, cpu_irq[0]}, 1);
        wr(0, A_MK, 32'h0000_0001);
        chk("R10 mask removed", {31'd0, cpu_irq[0]}, 0);
        wr(0, A_MK, 32'h0000_0200);
        chk("R10 mask restored", {31'd0, cpu_irq[0]}, 1);
        wr(0, A_SW, 32'h0);
        chk("R10 switch off", {31'd0, cpu_irq[0]}, 0);
        rd(0, A_PF, v); chk("R10 flags retained", v, 32'hF000_0200);

        // R6 gating uses pre-write mask: mask write and request same cycle
        wr(1, A_SW, 32'h1);
        wr(1, A_MK, 32'h0);
        src_req = 64'h0000_0001_0000_0000;
        wr(1, A_MK, 32'h0000_0001);
        src_req = '0;
        rd(1, A_PF, v); chk("R6 old mask gates", v, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule